// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A behavioural, synthesizable model of a flow-through synchronous burst SRAM. Each word is 36 bits wide and is organised as four 9-bit lanes: eight data bits plus one parity bit per lane. Every control, address and write-data input is captured on the rising clock edge. Read data for the address held in the internal address register appears in the same cycle, straight from the array, and is gated by an asynchronous output enable.

An access starts with the controller address strobe. In that cycle the three chip enables are evaluated. If they are valid, the supplied address is loaded and accessed. If any one of them is invalid, the core enters power-down. After a load, the advance input steps a 2-bit burst counter that wraps after four beats. The order is either linear or interleaved, and a mode input sampled at the load cycle selects which. Holding the advance input high inserts wait states at the current address. Writes are either a global full-word write or a write of the selected byte lanes.

Top module: `sburst_sram`

## Requirements
- R1: After reset the core is deselected. `dq_en` is 0 and `dq_out` is 0 until a valid load occurs.
- R2: A cycle with `ads_n`=0, `ce_n`=0, `ce2_n`=0, `ce_hi`=1 and no write loads `addr`. After that edge, with `oe_n`=0, `dq_en`=1 and `dq_out` equals the stored word.
- R3: With `gw_n`=0, all 36 bits at the effective address take `din`, whatever `bwe_n` and `bw_n` hold.
- R4: With `gw_n`=1 and `bwe_n`=0, the lane bits [9k+8:9k] are written only where `bw_n[k]`=0. The other lanes keep their old value.
- R5: With `gw_n`=1 and `bwe_n`=1, the cycle is a read and nothing is written, even when `bw_n` bits are 0.
- R6: With `ilv`=0 at the load cycle, each cycle with `ads_n`=1 and `adv_n`=0 moves the address to base[1:0]+count mod 4. The upper address bits stay fixed.
- R7: With `ilv`=1 at the load cycle, the low address bits follow base[1:0] XOR count.
- R8: A cycle with `ads_n`=1 and `adv_n`=1 keeps the current address, which gives a wait state.
- R9: The chip enables are ignored in cycles with `ads_n`=1. An active burst continues regardless of their values.
- R10: A cycle with `ads_n`=0 and any chip enable invalid writes nothing and leaves `dq_en` at 0. `dq_en` stays 0 until a valid load, and memory contents are kept.
- R11: `oe_n` acts combinationally, with no clock. When `oe_n`=1, `dq_en` is 0 and `dq_out` is 0.
- R12: `ads_n`=0 aborts a burst in progress and loads the new `addr`.
- R13: In the cycle after a write, the core does not drive, so `dq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the burst state |
| addr | input | AW | External address |
| ads_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global full-word write, active low |
| bwe_n | input | 1 | Byte write permit, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| din | input | LANES*LW | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LW | Read data, 0 when not driven |
| dq_en | output | 1 | Output drivers enabled |

## Verification
The bench overrides AW to 5, which gives a 32-word array. With that size, every word can be filled with a distinct pattern and read back, and there is room for several separate four-word burst groups. Lane count and width stay at their defaults. This keeps the lane mask, parity lanes and the full 36-bit override checkable against a bench reference array. Burst tests start at unaligned bases so that both the wrap of the linear order and the XOR order of the interleaved order are reached.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                ads_n,
  input  logic                adv_n,
  input  logic                ce_n,
  input  logic                ce2_n,
  input  logic                ce_hi,
  input  logic                ilv,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [LANES-1:0]    bw_n,
  input  logic [LANES*LW-1:0] din,
  input  logic                oe_n,
  output logic [LANES*LW-1:0] dq_out,
  output logic                dq_en
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          active, ilv_q, rd_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;

  function automatic logic [1:0] lo_of(input logic mode, input logic [1:0] b, input logic [1:0] c);
    return mode ? (b ^ c) : (b + c);
  endfunction

  wire             load    = !ads_n;
  wire             sel_ok  = !ce_n && !ce2_n && ce_hi;
  wire [1:0]       cnt_nx  = load ? 2'd0 : (adv_n ? cnt_q : cnt_q + 2'd1);
  wire [AW-1:0]    base_nx = load ? addr : base_q;
  wire             ilv_nx  = load ? ilv : ilv_q;
  wire             act_nx  = load ? sel_ok : active;
  wire [AW-1:0]    ea      = {base_nx[AW-1:2], lo_of(ilv_nx, base_nx[1:0], cnt_nx)};
  wire [AW-1:0]    cur     = {base_q[AW-1:2], lo_of(ilv_q, base_q[1:0], cnt_q)};
  wire [LANES-1:0] wmask   = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
  wire             do_wr   = act_nx && (|wmask);

  always_ff @(posedge clk) begin
    if (do_wr)
      for (int k = 0; k < LANES; k++)
        if (wmask[k]) mem[ea][k*LW +: LW] <= din[k*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      ilv_q  <= 1'b0;
      rd_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else begin
      active <= act_nx;
      ilv_q  <= ilv_nx;
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
      rd_q   <= act_nx && !(|wmask);
    end
  end

  assign dq_en  = active && rd_q && !oe_n;
  assign dq_out = dq_en ? mem[cur] : '0;
endmodule

module sburst_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ads_n,
  input logic          adv_n,
  input logic          ce_n,
  input logic          ce2_n,
  input logic          ce_hi,
  input logic          gw_n,
  input logic          bwe_n,
  input logic          oe_n,
  input logic          active,
  input logic [DW-1:0] dq_out,
  input logic          dq_en
);
  a_r10_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_n && !(!ce_n && !ce2_n && ce_hi)) |=> !dq_en);

  a_r10_stay_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && ads_n) |=> !active);

  a_r9_burst_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ads_n) |=> active);

  a_r8_wait_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_n && adv_n && gw_n && bwe_n && dq_en) |=> (oe_n || (dq_en && $stable(dq_out))));

  a_r13_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && (!ads_n || active)) |=> !dq_en);

  a_r11_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_en && dq_out == '0));
endmodule

bind sburst_sram sburst_sram_chk #(.DW(LANES*LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .adv_n(adv_n), .ce_n(ce_n),
  .ce2_n(ce2_n), .ce_hi(ce_hi), .gw_n(gw_n), .bwe_n(bwe_n), .oe_n(oe_n),
  .active(active), .dq_out(dq_out), .dq_en(dq_en)
);

// File: tb/test_sburst_sram.sv
`timescale 1ns/1ps
module test_sburst_sram;
  localparam int AW = 5;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic ads_n = 1, adv_n = 1, ce_n = 0, ce2_n = 0, ce_hi = 1, ilv = 0;
  logic gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [3:0] bw_n = 4'hF;
  logic [DW-1:0] din = '0, dq_out;
  logic dq_en;

  logic [DW-1:0] refm [1<<AW];
  int total = 0, fails = 0;

  sburst_sram #(.AW(AW)) i_sburst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ads_n(ads_n), .adv_n(adv_n),
    .ce_n(ce_n), .ce2_n(ce2_n), .ce_hi(ce_hi), .ilv(ilv), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .din(din), .oe_n(oe_n), .dq_out(dq_out), .dq_en(dq_en)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a) * 36'h0_1357_9BDF + 36'h9_8765_4321;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cyc(input logic l, input logic av, input logic g, input logic be,
                     input logic [3:0] b, input int a, input logic [DW-1:0] d);
    ads_n = !l; adv_n = !av; gw_n = g; bwe_n = be; bw_n = b; addr = AW'(a); din = d;
    tick();
    ads_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
  endtask

  task automatic expect_rd(input string tag, input int a);
    chk({tag, " en"}, DW'(dq_en), DW'(1));
    chk({tag, " data"}, dq_out, refm[a]);
  endtask

  task automatic t_reset();
    chk("R1 reset en", DW'(dq_en), DW'(0));
    chk("R1 reset data", dq_out, '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < (1<<AW); a++) begin
      cyc(1, 0, 0, 0, 4'hF, a, pat(a));
      refm[a] = pat(a);
      if (a == 3) chk("R13 no drive after write", DW'(dq_en), DW'(0));
    end
    for (int a = 0; a < (1<<AW); a += 5) begin
      cyc(1, 0, 1, 1, 4'hF, a, '0);
      expect_rd("R3 R2 full write readback", a);
    end
  endtask

  task automatic t_bytes();
    logic [DW-1:0] d = 36'hF_0F0F_0F0F;
    logic [3:0] b = 4'b1010;
    for (int k = 0; k < 4; k++)
      if (!b[k]) refm[5][k*9 +: 9] = d[k*9 +: 9];
    cyc(1, 0, 1, 0, b, 5, d);
    cyc(1, 0, 1, 1, 4'hF, 5, '0);
    expect_rd("R4 lane write", 5);
    cyc(1, 0, 1, 1, 4'h0, 7, 36'h0);
    expect_rd("R5 no write without permit", 7);
    cyc(1, 0, 1, 1, 4'hF, 7, '0);
    expect_rd("R5 contents kept", 7);
  endtask

  task automatic t_linear();
    int seq[5] = '{7, 4, 5, 5, 6};
    ilv = 0;
    cyc(1, 0, 1, 1, 4'hF, 6, '0);
    expect_rd("R6 load 6", 6);
    cyc(0, 1, 1, 1, 4'hF, 0, '0); expect_rd("R6 beat1", seq[0]);
    cyc(0, 1, 1, 1, 4'hF, 0, '0); expect_rd("R6 wrap", seq[1]);
    cyc(0, 1, 1, 1, 4'hF, 0, '0); expect_rd("R6 beat3", seq[2]);
    cyc(0, 0, 1, 1, 4'hF, 0, '0); expect_rd("R8 wait state", seq[3]);
    ce_n = 1; ce_hi = 0;
    cyc(0, 1, 1, 1, 4'hF, 0, '0); expect_rd("R9 enables ignored", seq[4]);
    ce_n = 0; ce_hi = 1;
  endtask

  task automatic t_ilv();
    int seq[3] = '{8, 11, 10};
    ilv = 1;
    cyc(1, 0, 1, 1, 4'hF, 9, '0);
    ilv = 0;
    expect_rd("R7 load 9", 9);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 1, 1, 4'hF, 0, '0);
      expect_rd("R7 interleaved beat", seq[i]);
    end
  endtask

  task automatic t_burst_write();
    cyc(1, 0, 0, 1, 4'hF, 12, 36'h1_1111_1111); refm[12] = 36'h1_1111_1111;
    cyc(0, 1, 0, 1, 4'hF, 0, 36'h2_2222_2222);
    cyc(0, 0, 0, 1, 4'hF, 0, 36'h3_3333_3333); refm[13] = 36'h3_3333_3333;
    chk("R13 burst write quiet", DW'(dq_en), DW'(0));
    cyc(1, 0, 1, 1, 4'hF, 12, '0); expect_rd("R3 burst write beat0", 12);
    cyc(0, 1, 1, 1, 4'hF, 0, '0);  expect_rd("R8 R6 burst write overwritten", 13);
  endtask

  task automatic t_powerdown();
    for (int i = 0; i < 3; i++) begin
      ce_n = (i == 0); ce2_n = (i == 1); ce_hi = (i != 2);
      cyc(1, 0, 0, 0, 4'h0, 3, 36'hA_AAAA_AAAA);
      ce_n = 0; ce2_n = 0; ce_hi = 1;
      chk("R10 power-down no drive", DW'(dq_en), DW'(0));
      cyc(0, 1, 0, 1, 4'hF, 0, 36'hB_BBBB_BBBB);
      cyc(0, 1, 1, 1, 4'hF, 0, '0);
      chk("R10 stays down", DW'(dq_en), DW'(0));
    end
    cyc(1, 0, 1, 1, 4'hF, 3, '0);
    expect_rd("R10 contents kept", 3);
    cyc(1, 0, 1, 1, 4'hF, 0, '0);
    expect_rd("R10 neighbour kept", 0);
  endtask

  task automatic t_oe();
    cyc(1, 0, 1, 1, 4'hF, 20, '0);
    #2 oe_n = 1; #1;
    chk("R11 oe off en", DW'(dq_en), DW'(0));
    chk("R11 oe off data", dq_out, '0);
    oe_n = 0; #1;
    expect_rd("R11 oe back on", 20);
  endtask

  task automatic t_abort();
    cyc(1, 0, 1, 1, 4'hF, 16, '0);
    cyc(0, 1, 1, 1, 4'hF, 0, '0);
    expect_rd("R12 burst step", 17);
    cyc(1, 1, 1, 1, 4'hF, 26, '0);
    expect_rd("R12 new address", 26);
  endtask

  initial begin
    #(10 * 100000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_bytes();
    t_linear();
    t_ilv();
    t_burst_write();
    t_powerdown();
    t_oe();
    t_abort();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule